// File: doc/BRIEF.md
# Presettable One-Hot Scan Pointer

This block models the address pointer that walks across the rows or columns of a 512-position pixel array. An external sequencer places a start address on a shared 9-bit address bus and opens a level-controlled start register, which follows the bus while its hold input is low and keeps its value while the hold input is high. A low-active preset input, honoured only while the shift clock is high, moves the pointer to the stored start position.

Each falling edge of the shift clock then moves the pointer one position on. When the pointer steps past the final position, it drops its valid flag and selects nothing. An active-low end-of-scan output goes low for the one shift-clock period that follows. The pointer stays empty until the next preset. Outputs are the one-hot select vector, the binary index of the selected position and a valid flag.

The shift clock, preset and hold inputs are slow control levels. The block samples them with a fast system clock and detects the shift-clock falling edge internally. Two row pointers (readout and reset) can share one start register, and a column pointer has its own. This block holds one start register and one pointer.

Top module: `scan_pointer`

## Requirements
- R1: After a synchronous active-low reset the pointer is invalid, no select bit is set, end-of-scan is high and the start register holds 0, so a preset with no prior load selects position 0.
- R2: The start register takes the bus value on every system clock edge while the hold input is 0, and keeps its value while the hold input is 1, whatever the bus does.
- R3: A system clock edge that sees the preset input low while the shift clock is high makes the pointer valid at the stored start position on the following cycle.
- R4: The preset input low while the shift clock is low has no effect on the pointer.
- R5: Each falling edge of the shift clock (high on one system clock edge, low on the next) advances a valid pointer by exactly one position. Rising edges and steady levels leave it unchanged.
- R6: The select vector has bit i set only for i equal to the index while the pointer is valid, and is all zeros while it is invalid.
- R7: A falling edge while the pointer is at position 511 makes the pointer invalid and drives end-of-scan low. End-of-scan returns high at the next shift-clock falling edge or preset.
- R8: Falling edges while the pointer is invalid change nothing: it stays invalid with all selects low.
- R9: When a load of the start register and a preset occur on the same system clock edge, the pointer takes the value held before that edge.
- R10: A stored start value serves any number of later presets without being reloaded.
- R11: A preset during a scan, or while end-of-scan is low, repositions the pointer at once and drives end-of-scan high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_bus | input | 9 | Shared start-address bus |
| start_hold | input | 1 | Start register control: 0 follows the bus, 1 holds |
| shift_clk | input | 1 | Shift clock level; the pointer moves on its falling edge |
| sync_n | input | 1 | Active-low preset, honoured while shift_clk is high |
| sel | output | 512 | One-hot position select |
| ptr_idx | output | 9 | Binary index of the selected position |
| ptr_valid | output | 1 | High while a position is selected |
| eos_n | output | 1 | Active-low end-of-scan |

## Verification
Two pairs of functions can meet in one system clock edge. The first pair is a start-register load and a preset. The bench opens the register onto a new address on the same edge that takes the preset, and expects the previously held address. A follow-up preset must then show the new one. The second pair is a preset and the pending end-of-scan. The bench presets while end-of-scan is low and expects a valid pointer with end-of-scan high on the next cycle.

// File: rtl/scanptr_pkg.sv
// Package: shared constants for the scan pointer.
// Assumes positions are numbered 0 .. NPOS-1 and scanned upward.
package scanptr_pkg;
    localparam int unsigned DEF_NPOS = 512;
    localparam int unsigned DEF_AW   = $clog2(DEF_NPOS);
endpackage

// File: rtl/scanptr_start_reg.sv
// Module: start-address register.
// Follows the address bus while hold is low, keeps its value while hold is
// high. Assumes the bus is stable around system clock edges.
module scanptr_start_reg #(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus,
    input  logic          hold,
    output logic [AW-1:0] start_q
);
    // Track the bus when open, keep the value when held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (!hold)
            start_q <= bus;
    end

    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(start_q));
    assert_track_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> start_q == $past(bus));
endmodule

// File: rtl/scanptr_edge.sv
// Module: falling-edge detector for the shift clock.
// Samples the shift clock level on the system clock; assumes each level
// lasts at least one system clock cycle.
module scanptr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic level_q;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= 1'b0;
        else
            level_q <= level;
    end

    // A fall is a high sample followed by a low one.
    always_comb fall = level_q & ~level;
endmodule

// File: rtl/scanptr_core.sv
// Module: pointer state: index, valid flag and end-of-scan.
// A preset (sync low while shift clock high) has priority; it cannot meet a
// falling edge in the same cycle because that needs the shift clock low.
module scanptr_core #(
    parameter int unsigned NPOS = 512,
    parameter int unsigned AW   = $clog2(NPOS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_q,
    input  logic          shift_lvl,
    input  logic          sync_n,
    input  logic          fall,
    output logic [AW-1:0] idx,
    output logic          valid,
    output logic          eos_n
);
    localparam logic [AW-1:0] LAST = AW'(NPOS - 1);

    logic preset;
    logic at_last;

    // Preset is accepted only while the shift clock is high.
    always_comb preset  = ~sync_n & shift_lvl;
    always_comb at_last = (idx == LAST);

    // Pointer update: preset, then step or run-off on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            valid <= 1'b0;
            eos_n <= 1'b1;
        end else if (preset) begin
            idx   <= start_q;
            valid <= 1'b1;
            eos_n <= 1'b1;
        end else if (fall) begin
            eos_n <= 1'b1;
            if (valid) begin
                if (at_last) begin
                    valid <= 1'b0;
                    eos_n <= 1'b0;
                end else begin
                    idx <= idx + AW'(1);
                end
            end
        end
    end

    assert_preset_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && shift_lvl) |=> (valid && idx == $past(start_q)));
    assert_low_sync_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_lvl && !fall) |=> ($stable(idx) && $stable(valid)));
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && valid && idx != LAST) |=> (valid && idx == $past(idx) + AW'(1)));
    assert_runoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && valid && idx == LAST) |=> (!valid && !eos_n));
    assert_eos_only_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !eos_n |-> !valid);
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && sync_n) |=> !valid);
endmodule

// File: rtl/scanptr_decode.sv
// Module: binary-to-one-hot select decoder.
// One comparator per position; all outputs low while the pointer is invalid.
module scanptr_decode #(
    parameter int unsigned NPOS = 512,
    parameter int unsigned AW   = $clog2(NPOS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   idx,
    input  logic            valid,
    output logic [NPOS-1:0] sel
);
    // One select line per array position.
    for (genvar i = 0; i < NPOS; i++) begin : g_pos
        assign sel[i] = valid && (idx == AW'(i));
    end

    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    assert_count_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 32'(valid));
endmodule

// File: rtl/scan_pointer.sv
// Module: presettable one-hot scan pointer (top).
// Start register, shift-clock edge detector, pointer state and decoder.
// Assumes control levels are synchronous to clk and each lasts one cycle or more.
module scan_pointer #(
    parameter int unsigned NPOS = scanptr_pkg::DEF_NPOS,
    localparam int unsigned AW  = $clog2(NPOS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr_bus,
    input  logic            start_hold,
    input  logic            shift_clk,
    input  logic            sync_n,
    output logic [NPOS-1:0] sel,
    output logic [AW-1:0]   ptr_idx,
    output logic            ptr_valid,
    output logic            eos_n
);
    logic [AW-1:0] start_q;
    logic          fall;

    scanptr_start_reg #(.AW(AW)) u_start (
        .clk(clk), .rst_n(rst_n), .bus(addr_bus), .hold(start_hold),
        .start_q(start_q)
    );

    scanptr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(shift_clk), .fall(fall)
    );

    scanptr_core #(.NPOS(NPOS), .AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .shift_lvl(shift_clk),
        .sync_n(sync_n), .fall(fall), .idx(ptr_idx), .valid(ptr_valid),
        .eos_n(eos_n)
    );

    scanptr_decode #(.NPOS(NPOS), .AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .idx(ptr_idx), .valid(ptr_valid), .sel(sel)
    );
endmodule

// File: tb/tb_scan_pointer.sv
module tb_scan_pointer;
    localparam int NPOS = 512;
    localparam int AW   = 9;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   addr_bus;
    logic            start_hold;
    logic            shift_clk;
    logic            sync_n;
    logic [NPOS-1:0] sel;
    logic [AW-1:0]   ptr_idx;
    logic            ptr_valid;
    logic            eos_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scan_pointer dut (
        .clk(clk), .rst_n(rst_n), .addr_bus(addr_bus), .start_hold(start_hold),
        .shift_clk(shift_clk), .sync_n(sync_n), .sel(sel), .ptr_idx(ptr_idx),
        .ptr_valid(ptr_valid), .eos_n(eos_n)
    );

    // Advance one system clock; inputs and samples sit 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare all outputs against an expected pointer state.
    task automatic expect_state(string req, bit ev, int ei, bit eeos);
        logic [NPOS-1:0] esel;
        esel = '0;
        if (ev) esel[ei] = 1'b1;
        checks++;
        if (ptr_valid !== ev || eos_n !== eeos || sel !== esel ||
            (ev && ptr_idx !== AW'(ei))) begin
            errors++;
            $display("FAIL %s: valid=%0b idx=%0d eos_n=%0b ones=%0d expected valid=%0b idx=%0d eos_n=%0b",
                     req, ptr_valid, ptr_idx, eos_n, $countones(sel), ev, ei, eeos);
        end
    endtask

    task automatic load_start(int a);
        addr_bus = AW'(a); start_hold = 1'b0; tick();
        start_hold = 1'b1; addr_bus = '1; tick();
    endtask

    task automatic preset();
        sync_n = 1'b0; tick();
        sync_n = 1'b1;
    endtask

    task automatic shift_pulse();
        shift_clk = 1'b0; tick();
        shift_clk = 1'b1; tick();
    endtask

    // R1: reset state and start register cleared to 0.
    task automatic t_reset();
        rst_n = 1'b0; addr_bus = 9'd77; start_hold = 1'b1; shift_clk = 1'b1; sync_n = 1'b1;
        tick(); tick();
        rst_n = 1'b1; tick();
        expect_state("R1 reset", 0, 0, 1);
        preset();
        expect_state("R1 start cleared", 1, 0, 1);
    endtask

    // R2/R3/R4: track, hold, preset, preset with shift low ignored.
    task automatic t_track_hold();
        addr_bus = 9'd37; start_hold = 1'b0; tick();
        start_hold = 1'b1; addr_bus = 9'd200; tick(); tick();
        preset();
        expect_state("R2 R3 held start", 1, 37, 1);
        shift_clk = 1'b0; tick();
        expect_state("R5 step", 1, 38, 1);
        sync_n = 1'b0; tick(); tick();
        sync_n = 1'b1;
        expect_state("R4 sync while shift low", 1, 38, 1);
        shift_clk = 1'b1; tick();
        expect_state("R5 rise no move", 1, 38, 1);
    endtask

    // R5/R6: several steps with idle cycles between.
    task automatic t_advance();
        for (int k = 0; k < 5; k++) begin
            shift_pulse();
            tick();
            expect_state("R5 R6 advance", 1, 39 + k, 1);
        end
    endtask

    // R7/R8: run past the last position.
    task automatic t_end();
        load_start(509);
        preset();
        expect_state("R3 preset 509", 1, 509, 1);
        shift_pulse(); shift_pulse();
        expect_state("R5 at last", 1, 511, 1);
        shift_clk = 1'b0; tick();
        expect_state("R7 run-off", 0, 0, 0);
        shift_clk = 1'b1; tick(); tick();
        expect_state("R7 eos held one period", 0, 0, 0);
        shift_pulse();
        expect_state("R7 eos release", 0, 0, 1);
        shift_pulse(); shift_pulse();
        expect_state("R8 idle falls", 0, 0, 1);
    endtask

    // R9/R10: load and preset on the same edge, then repeated presets.
    task automatic t_same_cycle();
        addr_bus = 9'd100; start_hold = 1'b0; sync_n = 1'b0; tick();
        start_hold = 1'b1; sync_n = 1'b1;
        expect_state("R9 old start used", 1, 509, 1);
        preset();
        expect_state("R9 new start later", 1, 100, 1);
        shift_pulse(); shift_pulse();
        expect_state("R5 from 100", 1, 102, 1);
        preset();
        expect_state("R10 no reload", 1, 100, 1);
    endtask

    // R11: preset mid-scan and while end-of-scan is low.
    task automatic t_midscan();
        shift_pulse();
        load_start(5);
        preset();
        expect_state("R11 mid-scan preset", 1, 5, 1);
        load_start(511);
        preset();
        shift_clk = 1'b0; tick();
        shift_clk = 1'b1; tick();
        expect_state("R7 run-off from 511", 0, 0, 0);
        load_start(3);
        expect_state("R7 eos still low", 0, 0, 0);
        preset();
        expect_state("R11 preset clears eos", 1, 3, 1);
    endtask

    initial begin
        t_reset();
        t_track_hold();
        t_advance();
        t_end();
        t_same_cycle();
        t_midscan();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule